// File: doc/BRIEF.md
# Trap Entry Router with Two-Level Delegation

This block sits at the trap-entry point of a hart that runs guests under a hypervisor. When an exception or an interrupt is signalled, it picks the privilege level that handles the trap: machine, hypervisor-supervisor (HS) or virtual-supervisor (VS). It also rewrites the environment-call code according to the mode that issued the call. In the same step it produces the updated privilege, virtualization and status fields that the rest of the hart loads on trap entry. Handler address selection, trap-value generation and the swapping of register banks belong to neighbouring logic.

Delegation is decided in two stages. The machine-level masks choose between machine mode and supervisor level. When virtualization is on, the hypervisor masks then choose between HS and VS, and a force-HS request can override them. The hypervisor status keeps a two-deep history: the previous virt bit and the previous supervisor privilege bit are pushed down one slot before the newest values are written. The caller presents the current mode and status fields as inputs. On a trap strobe the block registers its verdict and the updated copy of every field. When the parameter `HYP_EN` is 0, the hypervisor masks and all virt handling are ignored and only plain machine/supervisor delegation remains.

Top module: `trap_router`

## Requirements
- R1: A synchronous trap with code 8 (environment call) is rewritten from the current privilege (encoding U=0, S=1, M=3): machine gives 11, supervisor with virt on gives 10, supervisor with virt off gives 9, user keeps 8. Interrupts and all other codes pass unchanged.
- R2: `cause_o` carries the async flag in bit XLEN-1, the final code in its low CODE_W bits and zeros in between. Interrupts use the interrupt masks (`m_ideleg_i`, `h_ideleg_i`) and exceptions use the exception masks (`m_edeleg_i`, `h_edeleg_i`), indexed by the final code.
- R3: A trap goes to supervisor level only when the current privilege is U or S, the final code is below XLEN, and the selected machine mask bit is set. Otherwise it goes to machine mode. `target_o` encodes HS=1, VS=2, M=3 (0 after reset).
- R4: A supervisor-level trap goes to VS when virt is on, the selected hypervisor mask bit is set and force-HS is clear. The previous-virt, second-previous-virt, second-previous-privilege and STL fields are then left unchanged, and virt and force-HS stay as they were.
- R5: On an HS trap the history is pushed: `sp2v_o` takes `spv_i`, `sp2p_o` takes `spp_i`, and `spv_o` takes the current virt flag.
- R6: On an HS trap taken with virt on, `stl_o` takes the force-HS flag and both `virt_o` and `force_hs_o` become 0. Taken with virt off, `stl_o` and `force_hs_o` keep their inputs.
- R7: On a machine trap, `mpv_o` takes the current virt flag, `mtl_o` takes the force-HS flag and `virt_o` becomes 0. Force-HS and all supervisor-side fields keep their inputs.
- R8: Supervisor entry gives `spie_o`=`sie_i`, `spp_o`=current privilege bit 0, `sie_o`=0 and `priv_o`=1, with the machine fields unchanged. Machine entry gives `mpie_o`=`mie_i`, `mpp_o`=current privilege, `mie_o`=0 and `priv_o`=3.
- R9: All results are registered on the clock edge that samples `trap_valid_i` high, and `trap_done_o` is high for exactly the next cycle.
- R10: In a cycle without `trap_valid_i`, every output except `trap_done_o` keeps its value.
- R11: During reset `priv_o` is 3 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid_i | input | 1 | Trap request strobe |
| trap_async_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_code_i | input | CODE_W | Raw cause code |
| cur_priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| cur_virt_i | input | 1 | Current virtualization flag |
| cur_force_hs_i | input | 1 | Force traps to HS |
| m_edeleg_i | input | XLEN | Machine exception delegation mask |
| m_ideleg_i | input | XLEN | Machine interrupt delegation mask |
| h_edeleg_i | input | XLEN | Hypervisor exception delegation mask |
| h_ideleg_i | input | XLEN | Hypervisor interrupt delegation mask |
| sie_i | input | 1 | Supervisor interrupt enable |
| spie_i | input | 1 | Supervisor previous interrupt enable |
| spp_i | input | 1 | Supervisor previous privilege |
| mie_i | input | 1 | Machine interrupt enable |
| mpie_i | input | 1 | Machine previous interrupt enable |
| mpp_i | input | 2 | Machine previous privilege |
| spv_i | input | 1 | Hypervisor previous virt |
| sp2v_i | input | 1 | Hypervisor second previous virt |
| sp2p_i | input | 1 | Hypervisor second previous privilege |
| stl_i | input | 1 | Hypervisor trap-level record |
| mpv_i | input | 1 | Machine previous virt |
| mtl_i | input | 1 | Machine trap-level record |
| trap_done_o | output | 1 | Results updated in the previous edge |
| target_o | output | 2 | Handling level (HS=1, VS=2, M=3) |
| cause_o | output | XLEN | Final cause with async flag in MSB |
| priv_o | output | 2 | New privilege |
| virt_o | output | 1 | New virtualization flag |
| force_hs_o | output | 1 | New force-HS flag |
| sie_o | output | 1 | Updated supervisor interrupt enable |
| spie_o | output | 1 | Updated supervisor previous enable |
| spp_o | output | 1 | Updated supervisor previous privilege |
| mie_o | output | 1 | Updated machine interrupt enable |
| mpie_o | output | 1 | Updated machine previous enable |
| mpp_o | output | 2 | Updated machine previous privilege |
| spv_o | output | 1 | Updated previous virt |
| sp2v_o | output | 1 | Updated second previous virt |
| sp2p_o | output | 1 | Updated second previous privilege |
| stl_o | output | 1 | Updated trap-level record |
| mpv_o | output | 1 | Updated machine previous virt |
| mtl_o | output | 1 | Updated machine trap-level record |

## Verification
Every result of a trap (target, cause, mode and status fields, and the done pulse) is due one register stage after the edge that samples the strobe, and none is due earlier. The bench drives a request at a falling edge and computes the expected values at that moment from its own model. It compares them at the next falling edge, after the single capturing rising edge. Cycles without a strobe are checked the same way against the unchanged previous expectation. Reset values are compared while reset is held, and the first requests come only after the two-stage reset release has finished.

// File: rtl/trap_route_pkg.sv
package trap_route_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_HS   = 2'd1,
    TGT_VS   = 2'd2,
    TGT_M    = 2'd3
  } tgt_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int unsigned ECALL_U  = 8;
  localparam int unsigned ECALL_HS = 9;
  localparam int unsigned ECALL_VS = 10;
  localparam int unsigned ECALL_M  = 11;

  typedef struct packed {
    logic [1:0] priv;
    logic       virt;
    logic       force_hs;
  } mode_t;

  typedef struct packed {
    logic       sie;
    logic       spie;
    logic       spp;
    logic       mie;
    logic       mpie;
    logic [1:0] mpp;
    logic       spv;
    logic       sp2v;
    logic       sp2p;
    logic       stl;
    logic       mpv;
    logic       mtl;
  } stat_t;

endpackage

// File: rtl/trap_cause_xlate.sv
module trap_cause_xlate
  import trap_route_pkg::*;
#(
  parameter int unsigned CODE_W = 6,
  parameter bit          HYP_EN = 1'b1
) (
  input  logic              async_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  output logic [CODE_W-1:0] code_o
);

  logic is_ecall;
  logic virt_eff;

  assign is_ecall = !async_i && (code_i == CODE_W'(ECALL_U));
  assign virt_eff = HYP_EN && virt_i;

  always_comb begin
    code_o = code_i;
    if (is_ecall) begin
      unique case (priv_i)
        PRIV_M:  code_o = CODE_W'(ECALL_M);
        PRIV_S:  code_o = virt_eff ? CODE_W'(ECALL_VS) : CODE_W'(ECALL_HS);
        default: code_o = code_i;
      endcase
    end
  end

endmodule

// File: rtl/trap_deleg_sel.sv
module trap_deleg_sel
  import trap_route_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 6,
  parameter bit          HYP_EN = 1'b1
) (
  input  logic              async_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  input  logic              force_hs_i,
  input  logic [XLEN-1:0]   m_edeleg_i,
  input  logic [XLEN-1:0]   m_ideleg_i,
  input  logic [XLEN-1:0]   h_edeleg_i,
  input  logic [XLEN-1:0]   h_ideleg_i,
  output tgt_e              tgt_o
);

  localparam int unsigned IDX_W = $clog2(XLEN);

  logic             in_range;
  logic [IDX_W-1:0] idx;
  logic [XLEN-1:0]  m_mask;
  logic             m_hit;
  logic             to_vs;
  logic             low_priv;

  // The code may be wider than the mask index; codes at or above XLEN never delegate.
  generate
    if (CODE_W > IDX_W) begin : g_wide_code
      assign in_range = ~|code_i[CODE_W-1:IDX_W];
      assign idx      = code_i[IDX_W-1:0];
    end else begin : g_narrow_code
      assign in_range = 1'b1;
      assign idx      = IDX_W'(code_i);
    end
  endgenerate

  assign m_mask   = async_i ? m_ideleg_i : m_edeleg_i;
  assign m_hit    = in_range && m_mask[idx];
  assign low_priv = !priv_i[1];

  generate
    if (HYP_EN) begin : g_hyp
      logic [XLEN-1:0] h_mask;
      assign h_mask = async_i ? h_ideleg_i : h_edeleg_i;
      assign to_vs  = virt_i && h_mask[idx] && !force_hs_i;
    end else begin : g_nohyp
      logic unused_h;
      assign unused_h = ^{h_edeleg_i, h_ideleg_i, virt_i, force_hs_i};
      assign to_vs    = 1'b0;
    end
  endgenerate

  always_comb begin
    if (low_priv && m_hit) begin
      tgt_o = to_vs ? TGT_VS : TGT_HS;
    end else begin
      tgt_o = TGT_M;
    end
  end

endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd
  import trap_route_pkg::*;
#(
  parameter bit HYP_EN = 1'b1
) (
  input  tgt_e  tgt_i,
  input  mode_t mode_i,
  input  stat_t st_i,
  output mode_t mode_o,
  output stat_t st_o
);

  always_comb begin
    mode_o = mode_i;
    st_o   = st_i;
    if (!HYP_EN) begin
      mode_o.virt = 1'b0;
    end
    unique case (tgt_i)
      TGT_HS, TGT_VS: begin
        if (HYP_EN && tgt_i == TGT_HS) begin
          // history push: older slot first, then the newest virt value
          st_o.sp2v = st_i.spv;
          st_o.sp2p = st_i.spp;
          st_o.spv  = mode_i.virt;
          if (mode_i.virt) begin
            st_o.stl        = mode_i.force_hs;
            mode_o.virt     = 1'b0;
            mode_o.force_hs = 1'b0;
          end
        end
        st_o.spie   = st_i.sie;
        st_o.spp    = mode_i.priv[0];
        st_o.sie    = 1'b0;
        mode_o.priv = PRIV_S;
      end
      TGT_M: begin
        if (HYP_EN) begin
          st_o.mpv    = mode_i.virt;
          st_o.mtl    = mode_i.force_hs;
          mode_o.virt = 1'b0;
        end
        st_o.mpie   = st_i.mie;
        st_o.mpp    = mode_i.priv;
        st_o.mie    = 1'b0;
        mode_o.priv = PRIV_M;
      end
      default: begin
        st_o   = st_i;
        mode_o = mode_i;
      end
    endcase
  end

endmodule

// File: rtl/trap_router.sv
module trap_router
  import trap_route_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 6,
  parameter bit          HYP_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_valid_i,
  input  logic              trap_async_i,
  input  logic [CODE_W-1:0] trap_code_i,
  input  logic [1:0]        cur_priv_i,
  input  logic              cur_virt_i,
  input  logic              cur_force_hs_i,
  input  logic [XLEN-1:0]   m_edeleg_i,
  input  logic [XLEN-1:0]   m_ideleg_i,
  input  logic [XLEN-1:0]   h_edeleg_i,
  input  logic [XLEN-1:0]   h_ideleg_i,
  input  logic              sie_i,
  input  logic              spie_i,
  input  logic              spp_i,
  input  logic              mie_i,
  input  logic              mpie_i,
  input  logic [1:0]        mpp_i,
  input  logic              spv_i,
  input  logic              sp2v_i,
  input  logic              sp2p_i,
  input  logic              stl_i,
  input  logic              mpv_i,
  input  logic              mtl_i,
  output logic              trap_done_o,
  output logic [1:0]        target_o,
  output logic [XLEN-1:0]   cause_o,
  output logic [1:0]        priv_o,
  output logic              virt_o,
  output logic              force_hs_o,
  output logic              sie_o,
  output logic              spie_o,
  output logic              spp_o,
  output logic              mie_o,
  output logic              mpie_o,
  output logic [1:0]        mpp_o,
  output logic              spv_o,
  output logic              sp2v_o,
  output logic              sp2p_o,
  output logic              stl_o,
  output logic              mpv_o,
  output logic              mtl_o
);

  localparam int unsigned RST_STAGES = 2;

  // reset: asserted asynchronously, released through a short flop chain
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync_q[RST_STAGES-1];

  // decision path
  mode_t             cur_mode, nxt_mode;
  stat_t             cur_st, nxt_st;
  tgt_e              tgt_w;
  logic [CODE_W-1:0] code_x;
  logic [XLEN-1:0]   cause_w;

  assign cur_mode = '{priv: cur_priv_i, virt: cur_virt_i, force_hs: cur_force_hs_i};
  assign cur_st   = '{sie: sie_i, spie: spie_i, spp: spp_i, mie: mie_i, mpie: mpie_i,
                      mpp: mpp_i, spv: spv_i, sp2v: sp2v_i, sp2p: sp2p_i, stl: stl_i,
                      mpv: mpv_i, mtl: mtl_i};

  trap_cause_xlate #(.CODE_W(CODE_W), .HYP_EN(HYP_EN)) u_xlate (
    .async_i (trap_async_i),
    .code_i  (trap_code_i),
    .priv_i  (cur_priv_i),
    .virt_i  (cur_virt_i),
    .code_o  (code_x)
  );

  trap_deleg_sel #(.XLEN(XLEN), .CODE_W(CODE_W), .HYP_EN(HYP_EN)) u_deleg (
    .async_i    (trap_async_i),
    .code_i     (code_x),
    .priv_i     (cur_priv_i),
    .virt_i     (cur_virt_i),
    .force_hs_i (cur_force_hs_i),
    .m_edeleg_i (m_edeleg_i),
    .m_ideleg_i (m_ideleg_i),
    .h_edeleg_i (h_edeleg_i),
    .h_ideleg_i (h_ideleg_i),
    .tgt_o      (tgt_w)
  );

  trap_status_upd #(.HYP_EN(HYP_EN)) u_upd (
    .tgt_i  (tgt_w),
    .mode_i (cur_mode),
    .st_i   (cur_st),
    .mode_o (nxt_mode),
    .st_o   (nxt_st)
  );

  always_comb begin
    cause_w               = '0;
    cause_w[CODE_W-1:0]   = code_x;
    cause_w[XLEN-1]       = trap_async_i;
  end

  // result registers: next-state then flops
  logic            done_q, done_d;
  tgt_e            tgt_q, tgt_d;
  logic [XLEN-1:0] cause_q, cause_d;
  mode_t           mode_q, mode_d;
  stat_t           st_q, st_d;

  always_comb begin
    done_d  = trap_valid_i;
    tgt_d   = tgt_q;
    cause_d = cause_q;
    mode_d  = mode_q;
    st_d    = st_q;
    if (trap_valid_i) begin
      tgt_d   = tgt_w;
      cause_d = cause_w;
      mode_d  = nxt_mode;
      st_d    = nxt_st;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      done_q  <= 1'b0;
      tgt_q   <= TGT_NONE;
      cause_q <= '0;
      mode_q  <= '{priv: PRIV_M, virt: 1'b0, force_hs: 1'b0};
      st_q    <= '0;
    end else begin
      done_q  <= done_d;
      tgt_q   <= tgt_d;
      cause_q <= cause_d;
      mode_q  <= mode_d;
      st_q    <= st_d;
    end
  end

  assign trap_done_o = done_q;
  assign target_o    = tgt_q;
  assign cause_o     = cause_q;
  assign priv_o      = mode_q.priv;
  assign virt_o      = mode_q.virt;
  assign force_hs_o  = mode_q.force_hs;
  assign sie_o       = st_q.sie;
  assign spie_o      = st_q.spie;
  assign spp_o       = st_q.spp;
  assign mie_o       = st_q.mie;
  assign mpie_o      = st_q.mpie;
  assign mpp_o       = st_q.mpp;
  assign spv_o       = st_q.spv;
  assign sp2v_o      = st_q.sp2v;
  assign sp2p_o      = st_q.sp2p;
  assign stl_o       = st_q.stl;
  assign mpv_o       = st_q.mpv;
  assign mtl_o       = st_q.mtl;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    trap_valid_i |=> trap_done_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !trap_valid_i |=> (!trap_done_o && $stable(cause_o) && $stable(priv_o) && $stable(target_o)));

  // R3
  m_level_stays_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (trap_valid_i && cur_priv_i == PRIV_M) |=> (target_o == 2'(TGT_M)));

  // R4
  vs_keeps_hist_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (trap_valid_i && tgt_w == TGT_VS) |=>
      (virt_o && sp2v_o == $past(sp2v_i) && spv_o == $past(spv_i) && stl_o == $past(stl_i)));

  // R6
  hs_from_virt_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (trap_valid_i && tgt_w == TGT_HS && cur_virt_i) |=>
      (!virt_o && !force_hs_o && stl_o == $past(cur_force_hs_i)));

  // R7
  m_entry_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (trap_valid_i && tgt_w == TGT_M) |=>
      (priv_o == PRIV_M && !virt_o && !mie_o && mpv_o == $past(cur_virt_i)));

  // R8
  s_entry_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (trap_valid_i && (tgt_w == TGT_HS || tgt_w == TGT_VS)) |=>
      (priv_o == PRIV_S && !sie_o && spie_o == $past(sie_i)));

endmodule

// File: tb/tb_trap_router.sv
`timescale 1ns/1ps
module tb_trap_router;

  localparam int XL = 32;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic          v, a, vt, fh;
  logic [CW-1:0] code;
  logic [1:0]    p;
  logic [XL-1:0] me, mi, he, hi;
  logic          i_sie, i_spie, i_spp, i_mie, i_mpie, i_spv, i_sp2v, i_sp2p, i_stl, i_mpv, i_mtl;
  logic [1:0]    i_mpp;

  logic          o_done, o_virt, o_fh, o_sie, o_spie, o_spp, o_mie, o_mpie;
  logic          o_spv, o_sp2v, o_sp2p, o_stl, o_mpv, o_mtl;
  logic [1:0]    o_tgt, o_priv, o_mpp;
  logic [XL-1:0] o_cause;

  trap_router dut (
    .clk(clk), .rst_n(rst_n), .trap_valid_i(v), .trap_async_i(a), .trap_code_i(code),
    .cur_priv_i(p), .cur_virt_i(vt), .cur_force_hs_i(fh),
    .m_edeleg_i(me), .m_ideleg_i(mi), .h_edeleg_i(he), .h_ideleg_i(hi),
    .sie_i(i_sie), .spie_i(i_spie), .spp_i(i_spp), .mie_i(i_mie), .mpie_i(i_mpie),
    .mpp_i(i_mpp), .spv_i(i_spv), .sp2v_i(i_sp2v), .sp2p_i(i_sp2p), .stl_i(i_stl),
    .mpv_i(i_mpv), .mtl_i(i_mtl),
    .trap_done_o(o_done), .target_o(o_tgt), .cause_o(o_cause), .priv_o(o_priv),
    .virt_o(o_virt), .force_hs_o(o_fh), .sie_o(o_sie), .spie_o(o_spie), .spp_o(o_spp),
    .mie_o(o_mie), .mpie_o(o_mpie), .mpp_o(o_mpp), .spv_o(o_spv), .sp2v_o(o_sp2v),
    .sp2p_o(o_sp2p), .stl_o(o_stl), .mpv_o(o_mpv), .mtl_o(o_mtl)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // expected outputs
  int e_done, e_tgt, e_priv, e_virt, e_fh, e_sie, e_spie, e_spp, e_mie, e_mpie, e_mpp;
  int e_spv, e_sp2v, e_sp2p, e_stl, e_mpv, e_mtl;
  longint e_cause;
  string t_cause, t_tgt, t_hist, t_mode, t_m;

  task automatic chk(string tag, string what, longint got, longint expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, got, expv, $time);
    end
  endtask

  task automatic set_reset_exp();
    e_done = 0; e_tgt = 0; e_cause = 0; e_priv = 3; e_virt = 0; e_fh = 0;
    e_sie = 0; e_spie = 0; e_spp = 0; e_mie = 0; e_mpie = 0; e_mpp = 0;
    e_spv = 0; e_sp2v = 0; e_sp2p = 0; e_stl = 0; e_mpv = 0; e_mtl = 0;
  endtask

  // behavioural reference for one request
  task automatic model();
    int c, pv;
    bit dm, dh;
    e_done = v;
    if (!v) begin
      t_cause = "R10"; t_tgt = "R10"; t_hist = "R10"; t_mode = "R10"; t_m = "R10";
      return;
    end
    pv = int'(p);
    c = int'(code);
    t_cause = "R2";
    if (!a && c == 8) begin
      t_cause = "R1";
      if (pv == 3) c = 11;
      else if (pv == 1) c = vt ? 10 : 9;
    end
    dm = (c < XL) ? (a ? mi[c] : me[c]) : 1'b0;
    dh = (c < XL) ? (a ? hi[c] : he[c]) : 1'b0;
    e_cause = (longint'(a) << (XL - 1)) | longint'(c);
    e_sie = i_sie; e_spie = i_spie; e_spp = i_spp; e_mie = i_mie; e_mpie = i_mpie;
    e_mpp = int'(i_mpp); e_spv = i_spv; e_sp2v = i_sp2v; e_sp2p = i_sp2p; e_stl = i_stl;
    e_mpv = i_mpv; e_mtl = i_mtl; e_virt = vt; e_fh = fh;
    if (pv <= 1 && dm) begin
      t_mode = "R8"; t_m = "R8";
      if (vt && dh && !fh) begin
        e_tgt = 2; t_tgt = "R4"; t_hist = "R4";
      end else begin
        e_tgt = 1; t_tgt = "R3"; t_hist = "R5";
        e_sp2v = i_spv; e_sp2p = i_spp; e_spv = vt;
        if (vt) begin
          e_stl = fh; e_virt = 0; e_fh = 0;
        end
      end
      e_spie = i_sie; e_spp = pv & 1; e_sie = 0; e_priv = 1;
    end else begin
      e_tgt = 3; t_tgt = "R3"; t_hist = "R7"; t_mode = "R8"; t_m = "R7";
      e_mpv = vt; e_mtl = fh; e_virt = 0;
      e_mpie = i_mie; e_mpp = pv; e_mie = 0; e_priv = 3;
    end
  endtask

  task automatic compare_all();
    chk("R9", "trap_done", longint'(o_done), longint'(e_done));
    chk(t_cause, "cause", longint'(o_cause), e_cause);
    chk(t_tgt, "target", longint'(o_tgt), longint'(e_tgt));
    chk(t_mode, "priv", longint'(o_priv), longint'(e_priv));
    chk(t_mode, "s_ie_bits", longint'({o_sie, o_spie, o_spp}), longint'({e_sie[0], e_spie[0], e_spp[0]}));
    chk(t_mode, "m_ie_bits", longint'({o_mie, o_mpie, o_mpp}), longint'({e_mie[0], e_mpie[0], e_mpp[1:0]}));
    chk(t_hist == "R5" ? "R5" : t_hist, "hist", longint'({o_spv, o_sp2v, o_sp2p}),
        longint'({e_spv[0], e_sp2v[0], e_sp2p[0]}));
    chk(t_hist == "R5" ? "R6" : t_hist, "stl_virt_force", longint'({o_stl, o_virt, o_fh}),
        longint'({e_stl[0], e_virt[0], e_fh[0]}));
    chk(t_m, "mpv_mtl", longint'({o_mpv, o_mtl}), longint'({e_mpv[0], e_mtl[0]}));
  endtask

  // inputs are set at a falling edge; the next rising edge captures them
  task automatic tick();
    model();
    @(negedge clk);
    compare_all();
  endtask

  task automatic req(bit vv, bit aa, int cc, int pp, bit vvt, bit ffh);
    v = vv; a = aa; code = CW'(cc); p = 2'(pp); vt = vvt; fh = ffh;
    tick();
  endtask

  task automatic rand_status();
    {i_sie, i_spie, i_spp, i_mie, i_mpie, i_spv, i_sp2v, i_sp2p, i_stl, i_mpv, i_mtl} = 11'($urandom);
    i_mpp = 2'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    v = 0; a = 0; code = '0; p = 2'd0; vt = 0; fh = 0;
    me = '0; mi = '0; he = '0; hi = '0;
    {i_sie, i_spie, i_spp, i_mie, i_mpie, i_spv, i_sp2v, i_sp2p, i_stl, i_mpv, i_mtl} = '1;
    i_mpp = 2'd2;
    set_reset_exp();
    t_cause = "R11"; t_tgt = "R11"; t_hist = "R11"; t_mode = "R11"; t_m = "R11";
    repeat (3) @(negedge clk);
    // R11: reset values while reset is held
    chk("R11", "trap_done", longint'(o_done), 0);
    compare_all();
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) req(0, 0, 0, 0, 0, 0);

    // R1: ecall rewrite per mode, all routed to machine (no delegation)
    req(1, 0, 8, 3, 0, 0);
    req(1, 0, 8, 1, 1, 0);
    req(1, 0, 8, 1, 0, 0);
    req(1, 0, 8, 0, 0, 0);
    req(1, 1, 8, 1, 1, 0);
    // R2/R3: machine mask selection by async flag
    me = 32'h0000_0004; mi = 32'h0000_0020;
    req(1, 0, 2, 0, 0, 0);
    req(1, 1, 2, 0, 0, 0);
    req(1, 1, 5, 1, 0, 0);
    req(1, 0, 5, 1, 0, 0);
    // R3: code at/over XLEN never delegates, machine privilege never delegates
    me = '1; mi = '1;
    req(1, 0, 40, 0, 0, 0);
    req(1, 0, 32, 1, 0, 0);
    req(1, 0, 2, 3, 0, 0);
    // R4: VS routing keeps history; R5/R6: HS with and without virt, force-HS
    he = 32'h0000_0004; hi = '0;
    rand_status();
    req(1, 0, 2, 0, 1, 0);
    rand_status();
    req(1, 0, 2, 1, 1, 1);
    rand_status();
    req(1, 1, 2, 1, 1, 0);
    rand_status();
    req(1, 0, 2, 1, 0, 1);
    // R7: machine trap from virt with force-HS
    me = '0;
    rand_status();
    req(1, 0, 2, 1, 1, 1);
    // R10: idle cycles with changing inputs
    for (int k = 0; k < 3; k++) begin
      rand_status();
      req(0, 1, 3, 1, 1, 1);
    end
    // R1 R2 R3 R4 R5 R6 R7 R8 R9 R10: mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      int r;
      int pr;
      r = int'($urandom % 10);
      pr = int'($urandom % 3);
      me = (r == 9) ? '1 : $urandom;
      mi = $urandom;
      he = (r == 8) ? '1 : $urandom;
      hi = $urandom;
      rand_status();
      req(($urandom % 5) != 0, ($urandom % 4) == 0,
          (r < 3) ? 8 : (r == 3) ? 32 + int'($urandom % 32) : int'($urandom % 16),
          (pr == 2) ? 3 : pr, $urandom % 2 == 1, $urandom % 3 == 0);
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule